// File: doc/BRIEF.md
# Bidirectional inter-processor message mailbox

This block lets an application processor and an I/O coprocessor exchange fixed-size messages. Each message is a 64-bit word plus a 32-bit word. Two independent queues are built in. The outbound queue carries messages from the application side to the I/O side. The inbound queue carries them back. Both processors reach the same register set through one simple read/write bus port. Software tells the two directions apart by the register window it uses, not by which processor issued the access.

A producer writes the 64-bit word first. It then writes the 32-bit word, and that second write commits the pair as one queue entry. A consumer may read the 64-bit word of the oldest entry as often as it likes. Reading the 32-bit word removes the entry.

Each direction has a control/status word that reports full, empty and a sticky overflow. It drives two level interrupts:
- "queue not empty", towards the consumer.
- "queue empty", towards the producer.

The build-time parameter `IRQ_CTRL` selects between two interrupt schemes. When it is set, each direction has enable bits, and there is an acknowledge register for the not-empty interrupts. When it is clear, both interrupts are always enabled.

Top module: `ipc_mailbox`

Register map (byte addresses):
- `0x110`: outbound control/status.
- `0x114`: inbound control/status.
- `0x118`: acknowledge (write only).
- `0x800` to `0x818`: outbound window, with 64-bit word write, 32-bit word write, 64-bit word read and 32-bit word read at offsets `+0x0`, `+0x8`, `+0x10` and `+0x18`.
- `0x820` to `0x838`: inbound window, with the same four offsets.

## Requirements
- R1: Messages leave each queue in the order they were committed. The outbound and inbound queues never exchange or share entries.
- R2: Bit 16 of a control word reads 1 when that queue holds `DEPTH` entries. Bit 17 reads 1 when the queue holds none. Both bits reflect a commit or a removal from the cycle after it.
- R3: A 32-bit word write to a full queue is discarded and leaves the queue contents unchanged. It also sets bit 18 of that control word, and bit 18 then stays set until reset.
- R4: A read of the 32-bit word removes the oldest entry and returns its 32-bit word, zero-extended. A read of the 64-bit word leaves the queue unchanged.
- R5: Reading either word of an empty queue returns zero and does not change the queue.
- R6: Read data appears on `bus_rdata` one cycle after the read strobe. It holds until the next read.
- R7: The not-empty interrupt of a queue is high while that queue holds an entry and its enable (control bit 0) is set. It rises in the cycle after the commit.
- R8: A write to `0x118` acknowledges not-empty interrupts: bit 0 acknowledges the outbound queue and bit 1 the inbound queue. An acknowledge drops that interrupt for one cycle. The interrupt returns on the next cycle if the queue still holds an entry, so an entry that arrived around the acknowledge is not lost.
- R9: The empty interrupt of a queue is high while that queue is empty and its enable (control bit 1) is set. It falls in the cycle after a commit.
- R10: With `IRQ_CTRL` set, control bits 1:0 are writable and read back. With `IRQ_CTRL` clear, both enables read as 1 and acknowledges have no effect.
- R11: Reset empties both queues, clears both overflow flags, and clears the enables when `IRQ_CTRL` is set.
- R12: Each queue holds exactly `DEPTH` entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| irq_ap_recv | output | 1 | Inbound queue not empty, to the application side |
| irq_ap_send | output | 1 | Outbound queue empty, to the application side |
| irq_io_recv | output | 1 | Outbound queue not empty, to the I/O side |
| irq_io_send | output | 1 | Inbound queue empty, to the I/O side |

## Verification
Every result of this block is due exactly one clock edge after its stimulus:
- read data appears on the edge that takes the read strobe;
- status bits and both interrupts follow the edge that takes the commit write or the removing read;
- an acknowledge clears its interrupt on the edge that takes the write.

The bench drives each strobe for one cycle between falling edges and samples at the following falling edge. That gives every check exactly one rising edge of latency. The acknowledge check then waits one further falling edge to see the interrupt come back. An enable write takes effect one edge later than a commit, because the interrupt register reads the enable register, so the bench waits one extra cycle after writing an enable before it samples.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 12;
  localparam int W0_W   = 64;
  localparam int W1_W   = 32;
  localparam int MSG_W  = W0_W + W1_W;
  localparam int NCHAN  = 2;

  localparam int CTRL_BASE  = 'h110;
  localparam int CTRL_STEP  = 'h4;
  localparam int ACK_ADDR   = 'h118;
  localparam int WIN_BASE   = 'h800;
  localparam int WIN_STEP   = 'h20;
  localparam int OFF_PUT0   = 'h00;
  localparam int OFF_PUT1   = 'h08;
  localparam int OFF_GET0   = 'h10;
  localparam int OFF_GET1   = 'h18;

  localparam int FULL_BIT = 16;
  localparam int EMPTY_BIT = 17;
  localparam int OVF_BIT  = 18;

  typedef struct packed {
    logic [W0_W-1:0] w0;
    logic [W1_W-1:0] w1;
  } mbx_msg_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic             nonempty_next
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, count_next;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    count_next = count;
    if (do_push && !do_pop) count_next = count + 1'b1;
    else if (do_pop && !do_push) count_next = count - 1'b1;
  end
  assign nonempty_next = (count_next != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count_next;
    end
  end

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter bit IRQ_CTRL = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            put0_we,
  input  logic            put1_we,
  input  logic            get1_re,
  input  logic            ctrl_we,
  input  logic            ack_ne,
  input  logic [W0_W-1:0] wdata,
  output logic [W0_W-1:0] head_w0,
  output logic [W1_W-1:0] head_w1,
  output logic            full,
  output logic            empty,
  output logic            ovf,
  output logic [1:0]      irq_en,
  output logic            irq_ne,
  output logic            irq_em
);
  logic [W0_W-1:0] put0_q;
  mbx_msg_t        in_msg, head_msg;
  logic            ne_next, ack_eff;

  assign in_msg  = '{w0: put0_q, w1: wdata[W1_W-1:0]};
  assign ack_eff = ack_ne && IRQ_CTRL;

  mbx_fifo #(.DEPTH(DEPTH), .WIDTH(MSG_W)) u_fifo (
    .clk(clk), .rst(rst), .push(put1_we), .pop(get1_re),
    .wdata(in_msg), .head(head_msg), .full(full), .empty(empty),
    .nonempty_next(ne_next)
  );

  assign head_w0 = head_msg.w0;
  assign head_w1 = head_msg.w1;

  always_ff @(posedge clk) begin
    if (rst) begin
      put0_q <= '0;
      ovf    <= 1'b0;
      irq_en <= IRQ_CTRL ? 2'b00 : 2'b11;
      irq_ne <= 1'b0;
      irq_em <= 1'b0;
    end else begin
      if (put0_we) put0_q <= wdata;
      if (put1_we && full) ovf <= 1'b1;
      if (ctrl_we && IRQ_CTRL) irq_en <= wdata[1:0];
      irq_ne <= irq_en[0] && ne_next && !ack_eff;
      irq_em <= irq_en[1] && !ne_next;
    end
  end

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (put1_we && full) |=> (ovf && full));
  assert_ne_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq_ne |-> !empty);
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (rst)
    ack_eff |=> !irq_ne);
  assert_em_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq_em |-> empty);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter bit IRQ_CTRL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W0_W-1:0]   bus_wdata,
  output logic [W0_W-1:0]   bus_rdata,
  output logic              irq_ap_recv,
  output logic              irq_ap_send,
  output logic              irq_io_recv,
  output logic              irq_io_send
);
  logic [W0_W-1:0] h0 [NCHAN];
  logic [W1_W-1:0] h1 [NCHAN];
  logic [1:0]      en [NCHAN];
  logic [NCHAN-1:0] full, empty, ovf, ne, em;
  logic [W0_W-1:0] rd_val;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    localparam int WB = WIN_BASE + c * WIN_STEP;
    mbx_channel #(.DEPTH(DEPTH), .IRQ_CTRL(IRQ_CTRL)) u_chan (
      .clk(clk), .rst(rst),
      .put0_we(bus_wr && bus_addr == ADDR_W'(WB + OFF_PUT0)),
      .put1_we(bus_wr && bus_addr == ADDR_W'(WB + OFF_PUT1)),
      .get1_re(bus_rd && bus_addr == ADDR_W'(WB + OFF_GET1)),
      .ctrl_we(bus_wr && bus_addr == ADDR_W'(CTRL_BASE + c * CTRL_STEP)),
      .ack_ne(bus_wr && bus_addr == ADDR_W'(ACK_ADDR) && bus_wdata[c]),
      .wdata(bus_wdata),
      .head_w0(h0[c]), .head_w1(h1[c]),
      .full(full[c]), .empty(empty[c]), .ovf(ovf[c]), .irq_en(en[c]),
      .irq_ne(ne[c]), .irq_em(em[c])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NCHAN; c++) begin
      if (bus_addr == ADDR_W'(CTRL_BASE + c * CTRL_STEP)) begin
        rd_val[1:0]       = en[c];
        rd_val[FULL_BIT]  = full[c];
        rd_val[EMPTY_BIT] = empty[c];
        rd_val[OVF_BIT]   = ovf[c];
      end
      if (bus_addr == ADDR_W'(WIN_BASE + c * WIN_STEP + OFF_GET0) && !empty[c])
        rd_val = h0[c];
      if (bus_addr == ADDR_W'(WIN_BASE + c * WIN_STEP + OFF_GET1) && !empty[c])
        rd_val = {{(W0_W-W1_W){1'b0}}, h1[c]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign irq_io_recv = ne[0];
  assign irq_ap_send = em[0];
  assign irq_ap_recv = ne[1];
  assign irq_io_send = em[1];

  assert_hold_rdata_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        irq_ap_recv, irq_ap_send, irq_io_recv, irq_io_send;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ipc_mailbox #(.DEPTH(4), .IRQ_CTRL(1'b1)) i_ipc_mailbox (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ap_recv(irq_ap_recv), .irq_ap_send(irq_ap_send),
    .irq_io_recv(irq_io_recv), .irq_io_send(irq_io_send)
  );

  typedef struct packed {
    logic        is_rd;
    logic [11:0] addr;
    logic [63:0] data;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b0, 12'h800, 64'h1111_2222_3333_4444},
    '{1'b0, 12'h808, 64'h0000_0000_AAAA_0001},
    '{1'b0, 12'h820, 64'h5555_6666_7777_8888},
    '{1'b0, 12'h828, 64'h0000_0000_BBBB_0002},
    '{1'b0, 12'h800, 64'h0123_4567_89AB_CDEF},
    '{1'b0, 12'h808, 64'h0000_0000_CCCC_0003},
    '{1'b1, 12'h110, 64'h0},
    '{1'b1, 12'h810, 64'h1111_2222_3333_4444},
    '{1'b1, 12'h818, 64'h0000_0000_AAAA_0001},
    '{1'b1, 12'h810, 64'h0123_4567_89AB_CDEF},
    '{1'b1, 12'h830, 64'h5555_6666_7777_8888},
    '{1'b1, 12'h838, 64'h0000_0000_BBBB_0002},
    '{1'b1, 12'h114, 64'h0000_0000_0002_0000},
    '{1'b1, 12'h838, 64'h0},
    '{1'b1, 12'h818, 64'h0000_0000_CCCC_0003},
    '{1'b1, 12'h110, 64'h0000_0000_0002_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    rd(12'h110, v); check("R11 outbound ctrl after reset", v, 64'h20000);
    rd(12'h114, v); check("R11 inbound ctrl after reset", v, 64'h20000);
    check("R11 irqs after reset", {irq_ap_recv, irq_ap_send, irq_io_recv, irq_io_send}, 0);

    // R1 R2 R4 R5 R6 vector table
    for (int i = 0; i < 16; i++) begin
      if (VECS[i].is_rd) begin
        rd(VECS[i].addr, v);
        check($sformatf("R1/R4/R5/R6 vector %0d", i), v, VECS[i].data);
      end else begin
        wr(VECS[i].addr, VECS[i].data);
      end
    end

    // R12 R2 R3 fill and overflow
    wr(12'h800, 64'h0F0F);
    for (int k = 1; k <= 4; k++) wr(12'h808, 64'(k));
    rd(12'h110, v); check("R2 full bit at DEPTH R12", v, 64'h10000);
    wr(12'h808, 64'h99);
    rd(12'h110, v); check("R3 overflow set on full push", v, 64'h50000);
    for (int k = 1; k <= 4; k++) begin
      rd(12'h818, v); check("R3 dropped entry absent", v, 64'(k));
    end
    rd(12'h110, v); check("R3 overflow sticky", v, 64'h60000);

    // R10 R7 R8 R9 interrupts
    wr(12'h110, 64'h3);
    @(negedge clk);
    check("R9 empty irq when enabled", irq_ap_send, 1'b1);
    check("R7 no recv irq when empty", irq_io_recv, 1'b0);
    check("R10 inbound irqs stay disabled", {irq_ap_recv, irq_io_send}, 0);
    rd(12'h110, v); check("R10 enables read back", v, 64'h60003);
    wr(12'h808, 64'h77);
    check("R7 recv irq after commit", irq_io_recv, 1'b1);
    check("R9 empty irq falls after commit", irq_ap_send, 1'b0);
    wr(12'h808, 64'h78);
    wr(12'h118, 64'h1);
    check("R8 ack drops irq", irq_io_recv, 1'b0);
    @(negedge clk);
    check("R8 irq returns while not empty", irq_io_recv, 1'b1);
    rd(12'h818, v); check("R4 pop first", v, 64'h77);
    check("R7 irq held with one entry", irq_io_recv, 1'b1);
    rd(12'h818, v); check("R4 pop second", v, 64'h78);
    check("R7 irq falls when drained", irq_io_recv, 1'b0);
    check("R9 empty irq returns", irq_ap_send, 1'b1);

    // R11 reset mid-state
    wr(12'h808, 64'h55);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(12'h110, v); check("R11 ctrl cleared by reset", v, 64'h20000);
    rd(12'h818, v); check("R11 queue emptied by reset", v, 64'h0);
    check("R11 irqs low after reset", {irq_ap_recv, irq_ap_send, irq_io_recv, irq_io_send}, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule